// File: doc/BRIEF.md
# Beam Abort Trigger Combiner

This block takes the single-bit results of the threshold comparators that watch a stored beam and reduces them to a few abort lines for the machine protection system. The comparators cover several position channels, each with a positive and a negative excursion flag. They also cover a current-loss-rate detector, a current-above-threshold detector and an already latched bunch-overcharge detector. All horizontal flags merge into one X trip and all vertical flags into one Y trip. The bunch-overcharge trip and the current-loss-rate trip share a third line. A fourth line reports continuously whether the stored current is above its threshold.

Below the current threshold the beam cannot do damage. The X, Y and loss-rate trips are therefore suppressed while the current-high flag is low. Bunch overcharge is exempt from that suppression and fires at any current. Each trip line is active low and is stretched into a pulse of fixed length, `PULSE_CYCLES` clock cycles (1600 cycles, 8 µs at 200 MHz, by default). Every comparator flag enters through a two-flop synchronizer before any combining.

Top module: `abort_trig_combiner`

## Requirements
- R1: Any bit of `x_hi` or `x_lo`, with the current high, drives `x_trip_n` low, and `y_trip_n` and `loss_trip_n` stay high.
- R2: Any bit of `y_hi` or `y_lo`, with the current high, drives `y_trip_n` low, and `x_trip_n` and `loss_trip_n` stay high.
- R3: While the synchronized `cur_high` is 0, the position flags and `rate_trip` leave all three trip outputs high.
- R4: A `bunch_over` flag drives `loss_trip_n` low whether `cur_high` is 0 or 1.
- R5: `rate_trip`, with the current high, drives `loss_trip_n` low, which is the same output the bunch trip uses.
- R6: Trip outputs are active low (0 = trip, 1 = OK). A flag that is high for one cycle at the input makes the matching output go low at the third rising edge after the input changes. The output then stays low for exactly `PULSE_CYCLES` cycles.
- R7: A new trip condition during a running pulse restarts the count, so the output stays low until `PULSE_CYCLES` cycles after the last trip cycle.
- R8: `cur_status` follows `cur_high` two clock edges later with no stretching, so a one-cycle dip appears as a one-cycle dip.
- R9: During and after synchronous reset (`rst_n` low), all trip outputs are high and `cur_status` is 0 until a trip condition arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x_hi | input | N_XCH | Horizontal positive-excursion flags, one per channel |
| x_lo | input | N_XCH | Horizontal negative-excursion flags, one per channel |
| y_hi | input | N_YCH | Vertical positive-excursion flags, one per channel |
| y_lo | input | N_YCH | Vertical negative-excursion flags, one per channel |
| rate_trip | input | 1 | Current-loss-rate comparator flag |
| cur_high | input | 1 | Stored current above threshold |
| bunch_over | input | 1 | Latched bunch-overcharge flag |
| x_trip_n | output | 1 | Horizontal abort, active-low pulse |
| y_trip_n | output | 1 | Vertical abort, active-low pulse |
| loss_trip_n | output | 1 | Current-loss-rate or bunch-overcharge abort, active-low pulse |
| cur_status | output | 1 | Synchronized current-above-threshold status |

## Verification
The assertions check the following on every cycle:
- Each trip line sits low exactly while fewer than `PULSE_CYCLES` cycles have passed since its last gated trip condition. The checker tracks this with its own counter, so the single-pulse width and the restart rule are both covered.
- The current gate blocks the position and loss-rate paths.
- The bunch trip reaches the shared line.
- The status output lags its input by two edges.

The bench's scenarios show the properties seen only from the pins:
- The end-to-end three-edge latency from a raw input.
- That every individual flag bit lands on the correct output and on no other.
- The reset state.
- That a one-cycle current dip passes through unstretched.

// File: rtl/abort_trig_pkg.sv
// Shared definitions for the abort trigger combiner.
// Assumes: output lanes are indexed by the enum below everywhere.
package abort_trig_pkg;

    // Index of each stretched trip lane
    typedef enum int unsigned {
        LANE_X    = 0,
        LANE_Y    = 1,
        LANE_LOSS = 2
    } trip_lane_e;

    localparam int unsigned N_LANES = 3;

    // Number of single-bit flags besides the position vectors
    localparam int unsigned N_MISC_FLAGS = 3;

endpackage

// File: rtl/abort_sync2.sv
// Two-flop synchronizer for a vector of independent single-bit flags.
// Assumes: each bit is a level from an asynchronous comparator; bits are
// not required to stay coherent with each other across the crossing.
module abort_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two register stages, both cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign q_sync = stab_q;

endmodule

// File: rtl/abort_trip_merge.sv
// Reduces synchronized flags to one fire request per trip lane.
// X and Y position flags are ORed per axis; X, Y and loss-rate requests
// are gated by the current-high flag, while bunch overcharge bypasses it.
// Assumes: all inputs are already synchronous to clk.
module abort_trip_merge
    import abort_trig_pkg::*;
#(
    parameter int unsigned N_XCH = 4,
    parameter int unsigned N_YCH = 2
) (
    input  logic [N_XCH-1:0]   x_hi_s,
    input  logic [N_XCH-1:0]   x_lo_s,
    input  logic [N_YCH-1:0]   y_hi_s,
    input  logic [N_YCH-1:0]   y_lo_s,
    input  logic               rate_s,
    input  logic               cur_s,
    input  logic               bunch_s,
    output logic [N_LANES-1:0] fire
);

    logic x_any;
    logic y_any;

    // Per-axis OR across every channel and both polarities
    always_comb begin
        x_any = (|x_hi_s) | (|x_lo_s);
        y_any = (|y_hi_s) | (|y_lo_s);
    end

    // Current gate, with bunch overcharge ungated on the shared lane
    always_comb begin
        fire            = '0;
        fire[LANE_X]    = cur_s & x_any;
        fire[LANE_Y]    = cur_s & y_any;
        fire[LANE_LOSS] = bunch_s | (cur_s & rate_s);
    end

endmodule

// File: rtl/abort_pulse_stretch.sv
// Converts a fire request into an active-low pulse of WIDTH_CYC cycles.
// A request during a running pulse reloads the counter (retrigger).
// Assumes: WIDTH_CYC >= 1.
module abort_pulse_stretch #(
    parameter int unsigned WIDTH_CYC = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse_n
);

    localparam int unsigned CW = $clog2(WIDTH_CYC + 1);

    logic [CW-1:0] remain_q;

    // Load on request, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (fire) begin
            remain_q <= CW'(WIDTH_CYC);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - CW'(1);
        end
    end

    // Output is low while cycles remain
    assign pulse_n = (remain_q == '0);

endmodule

// File: rtl/abort_trig_combiner.sv
// Top of the abort trigger combiner: synchronizes all comparator flags,
// merges them into gated lane requests and stretches each request into
// an active-low pulse. Current status is passed on unstretched.
// Assumes: one clock domain; inputs may be asynchronous to it.
module abort_trig_combiner
    import abort_trig_pkg::*;
#(
    parameter int unsigned N_XCH        = 4,
    parameter int unsigned N_YCH        = 2,
    parameter int unsigned PULSE_CYCLES = 1600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_XCH-1:0] x_hi,
    input  logic [N_XCH-1:0] x_lo,
    input  logic [N_YCH-1:0] y_hi,
    input  logic [N_YCH-1:0] y_lo,
    input  logic             rate_trip,
    input  logic             cur_high,
    input  logic             bunch_over,
    output logic             x_trip_n,
    output logic             y_trip_n,
    output logic             loss_trip_n,
    output logic             cur_status
);

    localparam int unsigned SW = 2 * N_XCH + 2 * N_YCH + N_MISC_FLAGS;

    logic [SW-1:0]      raw_flags;
    logic [SW-1:0]      syn_flags;
    logic [N_XCH-1:0]   x_hi_s;
    logic [N_XCH-1:0]   x_lo_s;
    logic [N_YCH-1:0]   y_hi_s;
    logic [N_YCH-1:0]   y_lo_s;
    logic               rate_s;
    logic               cur_s;
    logic               bunch_s;
    logic [N_LANES-1:0] lane_fire;
    logic [N_LANES-1:0] lane_pulse_n;

    // Pack every comparator flag into one vector for the crossing
    assign raw_flags = {x_hi, x_lo, y_hi, y_lo, rate_trip, cur_high, bunch_over};

    abort_sync2 #(.W(SW)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_flags),
        .q_sync  (syn_flags)
    );

    // Unpack the synchronized flags in the same order
    assign {x_hi_s, x_lo_s, y_hi_s, y_lo_s, rate_s, cur_s, bunch_s} = syn_flags;

    abort_trip_merge #(
        .N_XCH (N_XCH),
        .N_YCH (N_YCH)
    ) u_merge (
        .x_hi_s  (x_hi_s),
        .x_lo_s  (x_lo_s),
        .y_hi_s  (y_hi_s),
        .y_lo_s  (y_lo_s),
        .rate_s  (rate_s),
        .cur_s   (cur_s),
        .bunch_s (bunch_s),
        .fire    (lane_fire)
    );

    // One stretcher per trip lane
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        abort_pulse_stretch #(.WIDTH_CYC(PULSE_CYCLES)) u_stretch (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire    (lane_fire[g]),
            .pulse_n (lane_pulse_n[g])
        );
    end

    assign x_trip_n    = lane_pulse_n[LANE_X];
    assign y_trip_n    = lane_pulse_n[LANE_Y];
    assign loss_trip_n = lane_pulse_n[LANE_LOSS];
    assign cur_status  = cur_s;

endmodule

// File: rtl/abort_trig_chk.sv
// Assertion checker for abort_trig_combiner, attached by bind below.
// Tracks, with its own counters, cycles since each lane's last gated
// trip condition and cycles since reset release.
module abort_trig_chk #(
    parameter int unsigned N_XCH        = 4,
    parameter int unsigned N_YCH        = 2,
    parameter int unsigned PULSE_CYCLES = 1600
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cur_high,
    input logic [N_XCH-1:0] x_hi_s,
    input logic [N_XCH-1:0] x_lo_s,
    input logic [N_YCH-1:0] y_hi_s,
    input logic [N_YCH-1:0] y_lo_s,
    input logic             rate_s,
    input logic             cur_s,
    input logic             bunch_s,
    input logic             x_trip_n,
    input logic             y_trip_n,
    input logic             loss_trip_n,
    input logic             cur_status
);

    localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

    logic          cond_x;
    logic          cond_y;
    logic          cond_l;
    logic [CW-1:0] quiet_x;
    logic [CW-1:0] quiet_y;
    logic [CW-1:0] quiet_l;
    logic [1:0]    since_rst;

    // Trip conditions rebuilt from the synchronized flags
    always_comb begin
        cond_x = cur_s && ((x_hi_s != '0) || (x_lo_s != '0));
        cond_y = cur_s && ((y_hi_s != '0) || (y_lo_s != '0));
        cond_l = bunch_s || (cur_s && rate_s);
    end

    // Saturating cycles-since-last-condition counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_x <= CW'(PULSE_CYCLES);
            quiet_y <= CW'(PULSE_CYCLES);
            quiet_l <= CW'(PULSE_CYCLES);
        end else begin
            quiet_x <= cond_x ? '0 : ((quiet_x == CW'(PULSE_CYCLES)) ? quiet_x : quiet_x + CW'(1));
            quiet_y <= cond_y ? '0 : ((quiet_y == CW'(PULSE_CYCLES)) ? quiet_y : quiet_y + CW'(1));
            quiet_l <= cond_l ? '0 : ((quiet_l == CW'(PULSE_CYCLES)) ? quiet_l : quiet_l + CW'(1));
        end
    end

    // Cycles since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R6
    x_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        x_trip_n == (quiet_x == CW'(PULSE_CYCLES)));
    // R7
    y_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_trip_n == (quiet_y == CW'(PULSE_CYCLES)));
    // R6
    loss_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loss_trip_n == (quiet_l == CW'(PULSE_CYCLES)));
    // R1
    x_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_s && ((x_hi_s != '0) || (x_lo_s != '0))) |=> !x_trip_n);
    // R2
    y_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_s && ((y_hi_s != '0) || (y_lo_s != '0))) |=> !y_trip_n);
    // R3
    x_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_s && x_trip_n) |=> x_trip_n);
    // R3
    y_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_s && y_trip_n) |=> y_trip_n);
    // R3
    rate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_s && !bunch_s && loss_trip_n) |=> loss_trip_n);
    // R4
    bunch_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bunch_s |=> !loss_trip_n);
    // R5
    rate_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_s && rate_s) |=> !loss_trip_n);
    // R8
    status_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (cur_status == $past(cur_high, 2)));

endmodule

bind abort_trig_combiner abort_trig_chk #(
    .N_XCH        (N_XCH),
    .N_YCH        (N_YCH),
    .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_high    (cur_high),
    .x_hi_s      (x_hi_s),
    .x_lo_s      (x_lo_s),
    .y_hi_s      (y_hi_s),
    .y_lo_s      (y_lo_s),
    .rate_s      (rate_s),
    .cur_s       (cur_s),
    .bunch_s     (bunch_s),
    .x_trip_n    (x_trip_n),
    .y_trip_n    (y_trip_n),
    .loss_trip_n (loss_trip_n),
    .cur_status  (cur_status)
);

// File: tb/abort_trig_combiner_tb.sv
// Directed bench for abort_trig_combiner: one task per scenario.
module abort_trig_combiner_tb;

    localparam int unsigned NX = 4;
    localparam int unsigned NY = 2;
    localparam int unsigned P  = 1600;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NX-1:0] x_hi = '0;
    logic [NX-1:0] x_lo = '0;
    logic [NY-1:0] y_hi = '0;
    logic [NY-1:0] y_lo = '0;
    logic          rate_trip = 1'b0;
    logic          cur_high = 1'b0;
    logic          bunch_over = 1'b0;
    logic          x_trip_n;
    logic          y_trip_n;
    logic          loss_trip_n;
    logic          cur_status;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    abort_trig_combiner #(.N_XCH(NX), .N_YCH(NY), .PULSE_CYCLES(P)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .x_hi        (x_hi),
        .x_lo        (x_lo),
        .y_hi        (y_hi),
        .y_lo        (y_lo),
        .rate_trip   (rate_trip),
        .cur_high    (cur_high),
        .bunch_over  (bunch_over),
        .x_trip_n    (x_trip_n),
        .y_trip_n    (y_trip_n),
        .loss_trip_n (loss_trip_n),
        .cur_status  (cur_status)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag, input logic ex, input logic ey, input logic el);
        chk({tag, " x_trip_n"}, x_trip_n, ex);
        chk({tag, " y_trip_n"}, y_trip_n, ey);
        chk({tag, " loss_trip_n"}, loss_trip_n, el);
    endtask

    // One-cycle input pulse; returns at the negedge after the load edge
    task automatic fire(input logic [NX-1:0] xh, input logic [NX-1:0] xl,
                        input logic [NY-1:0] yh, input logic [NY-1:0] yl,
                        input logic rt, input logic bo);
        @(negedge clk);
        x_hi = xh; x_lo = xl; y_hi = yh; y_lo = yl; rate_trip = rt; bunch_over = bo;
        @(negedge clk);
        x_hi = '0; x_lo = '0; y_hi = '0; y_lo = '0; rate_trip = 1'b0; bunch_over = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (P + 2) @(negedge clk);
    endtask

    task automatic set_current(input logic v);
        @(negedge clk);
        cur_high = v;
        repeat (3) @(negedge clk);
    endtask

    // R9: reset state
    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk_outs("R9 in reset", 1'b1, 1'b1, 1'b1);
        chk("R9 cur_status in reset", cur_status, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_outs("R9 after reset", 1'b1, 1'b1, 1'b1);
    endtask

    // R1: each X flag bit reaches only the X output
    task automatic t_x_each();
        for (int i = 0; i < NX; i++) begin
            fire(NX'(1) << i, '0, '0, '0, 1'b0, 1'b0);
            chk_outs($sformatf("R1 x_hi[%0d]", i), 1'b0, 1'b1, 1'b1);
            settle();
            fire('0, NX'(1) << i, '0, '0, 1'b0, 1'b0);
            chk_outs($sformatf("R1 x_lo[%0d]", i), 1'b0, 1'b1, 1'b1);
            settle();
        end
    endtask

    // R2: each Y flag bit reaches only the Y output
    task automatic t_y_each();
        for (int i = 0; i < NY; i++) begin
            fire('0, '0, NY'(1) << i, '0, 1'b0, 1'b0);
            chk_outs($sformatf("R2 y_hi[%0d]", i), 1'b1, 1'b0, 1'b1);
            settle();
            fire('0, '0, '0, NY'(1) << i, 1'b0, 1'b0);
            chk_outs($sformatf("R2 y_lo[%0d]", i), 1'b1, 1'b0, 1'b1);
            settle();
        end
    endtask

    // R5: loss-rate flag drives the shared loss output
    task automatic t_rate();
        fire('0, '0, '0, '0, 1'b1, 1'b0);
        chk_outs("R5 rate trip", 1'b1, 1'b1, 1'b0);
        settle();
        chk_outs("R5 rate trip ended", 1'b1, 1'b1, 1'b1);
    endtask

    // R6: exact pulse width
    task automatic t_width();
        fire(NX'(1), '0, '0, '0, 1'b0, 1'b0);
        chk("R6 first low cycle", x_trip_n, 1'b0);
        repeat (P - 1) @(negedge clk);
        chk("R6 last low cycle", x_trip_n, 1'b0);
        @(negedge clk);
        chk("R6 released after width", x_trip_n, 1'b1);
        settle();
    endtask

    // R7: retrigger restarts the count
    task automatic t_restart();
        fire('0, '0, NY'(1), '0, 1'b0, 1'b0);
        repeat (7) @(negedge clk);
        fire('0, '0, '0, NY'(1), 1'b0, 1'b0);
        repeat (P - 11) @(negedge clk);
        chk("R7 still low past first pulse end", y_trip_n, 1'b0);
        repeat (10) @(negedge clk);
        chk("R7 low on last restarted cycle", y_trip_n, 1'b0);
        @(negedge clk);
        chk("R7 released after restarted width", y_trip_n, 1'b1);
        settle();
    endtask

    // R3: gating below current threshold
    task automatic t_gate();
        set_current(1'b0);
        chk("R8 status low", cur_status, 1'b0);
        fire('1, '1, '1, '1, 1'b1, 1'b0);
        chk_outs("R3 gated", 1'b1, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        chk_outs("R3 gated later", 1'b1, 1'b1, 1'b1);
    endtask

    // R4: bunch trip at low and high current
    task automatic t_bunch();
        fire('0, '0, '0, '0, 1'b0, 1'b1);
        chk_outs("R4 bunch at low current", 1'b1, 1'b1, 1'b0);
        settle();
        set_current(1'b1);
        fire('0, '0, '0, '0, 1'b0, 1'b1);
        chk_outs("R4 bunch at high current", 1'b1, 1'b1, 1'b0);
        settle();
    endtask

    // R8: one-cycle dip passes through unstretched
    task automatic t_status();
        @(negedge clk);
        cur_high = 1'b0;
        @(negedge clk);
        cur_high = 1'b1;
        chk("R8 before dip arrives", cur_status, 1'b1);
        @(negedge clk);
        chk("R8 dip visible", cur_status, 1'b0);
        @(negedge clk);
        chk("R8 dip one cycle", cur_status, 1'b1);
    endtask

    initial begin
        t_reset();
        set_current(1'b1);
        chk("R8 status high", cur_status, 1'b1);
        t_x_each();
        t_y_each();
        t_rate();
        t_width();
        t_restart();
        t_gate();
        t_bunch();
        t_status();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule